// File: doc/BRIEF.md
# Requester-Side Coherence Agent

This block is the coherence agent of one node in a directory-based shared-memory system. It sits between the node's local cache port and a point-to-point message network. When a local access misses, it sends exactly one request to the home node of the line (the node whose number equals the low bits of the line index). It then drives the rest of the exchange: it installs clean data sent by the home, or it fetches the line from an owner that the home names, or, for a write, it invalidates every sharer that the home lists and counts their acknowledgements before it lets the write land.

The agent also answers traffic aimed at its own copies. A data request from another node returns the line to that node, sends the same data to the line's home as a revision, and drops the local copy to shared. An invalidation clears the local copy and is acknowledged to the sender. Per-line state (invalid, shared, modified) and line data are held in a small register file, which can be read through a probe port.

Both network ports use valid/ready. A message moves on a rising edge where valid and ready are both high. Once the agent raises `tx_valid`, it holds the valid signal and every message field steady until `tx_ready` is seen. On the receive side, `rx_ready` may drop while the agent is still sending replies to an earlier data request or invalidation. Replies addressed to the agent itself are always accepted. The local request port is also valid/ready, and `req_ready` stays low while a miss is outstanding.

Top module: `coh_req_agent`

## Requirements
- R1: A local miss produces exactly one request message, sent to the node numbered `line mod NODES`. A read miss uses type code 0 and a write miss uses type code 1. No other node receives a request.
- R2: A local read of a line in state shared (1) or modified (2) completes without any network message. `cpl_valid` pulses for one cycle, one cycle after the request is accepted, and `cpl_rdata` carries the stored data.
- R3: After reset every line is invalid (state code 0). A home reply of type 5 (data) to a read miss completes the read with that data and leaves the line shared (1).
- R4: A home reply of type 8 names an owner in the low bits of the data field. The agent then sends a data request (type 2) to that owner. The owner's type-5 data completes the read and leaves the line shared.
- R5: A local write to a modified line completes without any network message, and the stored data takes the write value.
- R6: A local write to a shared or invalid line first obtains exclusive access through a write-miss request (type 1).
- R7: A home reply of type 7 carries data and a sharer vector in which bit i stands for node i. The agent sends one invalidate (type 3) to each listed node other than itself. Its own bit in the vector is ignored.
- R8: A pending write completes only after an acknowledgement (type 4) has arrived for every invalidate sent, in any order. The line then becomes modified and holds the write data.
- R9: If the sharer vector, with the agent's own bit removed, is empty, the write completes at once and no invalidate is sent.
- R10: An incoming data request (type 2) returns the line data to the requester as type 5, then sends the same data to the line's home as a revision (type 6). A modified copy drops to shared.
- R11: An incoming invalidate (type 3) sets the target line to invalid and sends an acknowledgement (type 4) to the sender.
- R12: Only one miss is outstanding at a time. `req_ready` is low from the acceptance of a missing request until its completion, and it is high after reset.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_type`, `tx_dst`, `tx_line` and `tx_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local access request valid |
| req_ready | output | 1 | Agent can accept a local access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | $clog2(LINES) | Line index of the access |
| req_wdata | input | DW | Write data |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_rdata | output | DW | Read data, or the written data for a write |
| rx_valid | input | 1 | Incoming message valid |
| rx_ready | output | 1 | Incoming message accepted |
| rx_type | input | 4 | Incoming message type code |
| rx_src | input | $clog2(NODES) | Sending node |
| rx_line | input | $clog2(LINES) | Line the message concerns |
| rx_data | input | DW | Line data, or owner number in the low bits |
| rx_sharers | input | NODES | Sharer vector of a write grant |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Network takes the outgoing message |
| tx_type | output | 4 | Outgoing message type code |
| tx_dst | output | $clog2(NODES) | Destination node |
| tx_line | output | $clog2(LINES) | Line the message concerns |
| tx_data | output | DW | Line data carried by the message |
| probe_line | input | $clog2(LINES) | Line to inspect |
| probe_state | output | 2 | State of the probed line (0 I, 1 S, 2 M) |
| probe_data | output | DW | Stored data of the probed line |

## Verification
The hardest case to reach from the ports is a write that is held back by acknowledgements. The sharer vector must include several remote nodes and often the agent's own bit, and the acknowledgements must arrive in an order unrelated to the order in which the invalidates went out. The bench acts as the home and as every remote node. It answers each write grant with a random sharer vector and returns the acknowledgements in shuffled order. Before releasing the last acknowledgement, it pauses to confirm that no completion has appeared. Random back-pressure on the transmit port holds messages in flight, and between local accesses the bench injects incoming data requests and invalidations.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [3:0] {
    MSG_RD_MISS  = 4'd0,
    MSG_WR_MISS  = 4'd1,
    MSG_DATA_REQ = 4'd2,
    MSG_INV      = 4'd3,
    MSG_INV_ACK  = 4'd4,
    MSG_DATA     = 4'd5,
    MSG_REVISION = 4'd6,
    MSG_GRANT    = 4'd7,
    MSG_OWNER    = 4'd8
  } msg_e;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } ln_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store #(
  parameter int LINES = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     a_we,
  input  logic [$clog2(LINES)-1:0] a_line,
  input  logic [1:0]               a_state,
  input  logic [DW-1:0]            a_data,
  input  logic                     b_we,
  input  logic [$clog2(LINES)-1:0] b_line,
  input  logic [1:0]               b_state,
  input  logic [$clog2(LINES)-1:0] ra_line,
  output logic [1:0]               ra_state,
  output logic [DW-1:0]            ra_data,
  input  logic [$clog2(LINES)-1:0] rb_line,
  output logic [1:0]               rb_state,
  output logic [DW-1:0]            rb_data,
  input  logic [$clog2(LINES)-1:0] rc_line,
  output logic [1:0]               rc_state,
  output logic [DW-1:0]            rc_data
);
  logic [1:0]    st_q [LINES];
  logic [DW-1:0] dt_q [LINES];

  // port A (miss engine) writes state and data; port B (service) writes
  // state only and is applied last so a downgrade or invalidate wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i] <= coh_pkg::LN_I;
        dt_q[i] <= '0;
      end
    end else begin
      if (a_we) begin
        st_q[a_line] <= a_state;
        dt_q[a_line] <= a_data;
      end
      if (b_we) st_q[b_line] <= b_state;
    end
  end

  assign ra_state = st_q[ra_line];
  assign ra_data  = dt_q[ra_line];
  assign rb_state = st_q[rb_line];
  assign rb_data  = dt_q[rb_line];
  assign rc_state = st_q[rc_line];
  assign rc_data  = dt_q[rc_line];
endmodule

// File: rtl/coh_miss_fsm.sv
module coh_miss_fsm
  import coh_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int LINES   = 16,
  parameter int DW      = 32,
  parameter int NODE_ID = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [$clog2(LINES)-1:0] req_line,
  input  logic [DW-1:0]            req_wdata,
  input  logic [1:0]               lk_state,
  input  logic [DW-1:0]            lk_data,
  output logic                     cpl_valid,
  output logic [DW-1:0]            cpl_rdata,
  input  logic                     rx_valid,
  input  logic [3:0]               rx_type,
  input  logic [$clog2(LINES)-1:0] rx_line,
  input  logic [DW-1:0]            rx_data,
  input  logic [NODES-1:0]         rx_sharers,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic [3:0]               m_type,
  output logic [$clog2(NODES)-1:0] m_dst,
  output logic [$clog2(LINES)-1:0] m_line,
  output logic [DW-1:0]            m_data,
  output logic                     st_we,
  output logic [$clog2(LINES)-1:0] st_line,
  output logic [1:0]               st_state,
  output logic [DW-1:0]            st_data
);
  localparam int NW = $clog2(NODES);
  localparam int LW = $clog2(LINES);
  localparam int CW = $clog2(NODES + 1);
  localparam logic [NODES-1:0] SELF = NODES'(1) << NODE_ID;

  typedef enum logic [2:0] {
    F_IDLE, F_SEND_MISS, F_WAIT_HOME, F_SEND_DREQ, F_WAIT_DATA, F_SEND_INV, F_WAIT_ACK
  } fst_e;

  fst_e            st_q;
  logic            cur_write;
  logic [LW-1:0]   cur_line;
  logic [DW-1:0]   cur_wdata;
  logic [NW-1:0]   owner_q;
  logic [NODES-1:0] inv_left;
  logic [CW-1:0]   ack_cnt;
  logic            cpl_q;
  logic [DW-1:0]   cpl_data_q;

  function automatic logic [CW-1:0] popc(input logic [NODES-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < NODES; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic             hit, rx_hit;
  logic             home_data, home_owner, home_grant, own_data, ack_in;
  logic [NODES-1:0] grant_set, inv_onehot, inv_rest;
  logic [NW-1:0]    inv_idx;

  assign hit       = (lk_state == LN_M) || (lk_state == LN_S && !req_write);
  assign rx_hit    = rx_valid && (rx_line == cur_line);
  assign home_data = (st_q == F_WAIT_HOME) && rx_hit && !cur_write && rx_type == MSG_DATA;
  assign home_owner= (st_q == F_WAIT_HOME) && rx_hit && !cur_write && rx_type == MSG_OWNER;
  assign home_grant= (st_q == F_WAIT_HOME) && rx_hit && cur_write && rx_type == MSG_GRANT;
  assign own_data  = (st_q == F_WAIT_DATA) && rx_hit && rx_type == MSG_DATA;
  assign ack_in    = (st_q == F_SEND_INV || st_q == F_WAIT_ACK) && rx_hit &&
                     rx_type == MSG_INV_ACK && ack_cnt != '0;
  assign grant_set = rx_sharers & ~SELF;
  assign inv_onehot= inv_left & (~inv_left + NODES'(1));
  assign inv_rest  = inv_left & ~inv_onehot;

  always_comb begin
    inv_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) if (inv_left[i]) inv_idx = NW'(i);
  end

  always_comb begin
    req_ready = (st_q == F_IDLE);
    m_valid   = 1'b0;
    m_type    = MSG_RD_MISS;
    m_dst     = cur_line[NW-1:0];
    m_line    = cur_line;
    m_data    = '0;
    st_we     = 1'b0;
    st_line   = cur_line;
    st_state  = LN_S;
    st_data   = rx_data;
    case (st_q)
      F_IDLE: if (req_valid && hit && req_write) begin
        st_we    = 1'b1;
        st_line  = req_line;
        st_state = LN_M;
        st_data  = req_wdata;
      end
      F_SEND_MISS: begin
        m_valid = 1'b1;
        m_type  = cur_write ? MSG_WR_MISS : MSG_RD_MISS;
      end
      F_WAIT_HOME: begin
        if (home_data) st_we = 1'b1;
        if (home_grant && grant_set == '0) begin
          st_we    = 1'b1;
          st_state = LN_M;
          st_data  = cur_wdata;
        end
      end
      F_SEND_DREQ: begin
        m_valid = 1'b1;
        m_type  = MSG_DATA_REQ;
        m_dst   = owner_q;
      end
      F_WAIT_DATA: if (own_data) st_we = 1'b1;
      F_SEND_INV: begin
        m_valid = 1'b1;
        m_type  = MSG_INV;
        m_dst   = inv_idx;
      end
      F_WAIT_ACK: if (ack_cnt == '0) begin
        st_we    = 1'b1;
        st_state = LN_M;
        st_data  = cur_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= F_IDLE;
      cur_write  <= 1'b0;
      cur_line   <= '0;
      cur_wdata  <= '0;
      owner_q    <= '0;
      inv_left   <= '0;
      ack_cnt    <= '0;
      cpl_q      <= 1'b0;
      cpl_data_q <= '0;
    end else begin
      cpl_q <= 1'b0;
      case (st_q)
        F_IDLE: if (req_valid) begin
          cur_line  <= req_line;
          cur_write <= req_write;
          cur_wdata <= req_wdata;
          if (hit) begin
            cpl_q      <= 1'b1;
            cpl_data_q <= req_write ? req_wdata : lk_data;
          end else begin
            st_q <= F_SEND_MISS;
          end
        end
        F_SEND_MISS: if (m_ready) st_q <= F_WAIT_HOME;
        F_WAIT_HOME: begin
          if (home_data) begin
            cpl_q      <= 1'b1;
            cpl_data_q <= rx_data;
            st_q       <= F_IDLE;
          end else if (home_owner) begin
            owner_q <= rx_data[NW-1:0];
            st_q    <= F_SEND_DREQ;
          end else if (home_grant) begin
            inv_left <= grant_set;
            ack_cnt  <= popc(grant_set);
            if (grant_set == '0) begin
              cpl_q      <= 1'b1;
              cpl_data_q <= cur_wdata;
              st_q       <= F_IDLE;
            end else begin
              st_q <= F_SEND_INV;
            end
          end
        end
        F_SEND_DREQ: if (m_ready) st_q <= F_WAIT_DATA;
        F_WAIT_DATA: if (own_data) begin
          cpl_q      <= 1'b1;
          cpl_data_q <= rx_data;
          st_q       <= F_IDLE;
        end
        F_SEND_INV: if (m_ready) begin
          inv_left <= inv_rest;
          if (inv_rest == '0) st_q <= F_WAIT_ACK;
        end
        F_WAIT_ACK: if (ack_cnt == '0) begin
          cpl_q      <= 1'b1;
          cpl_data_q <= cur_wdata;
          st_q       <= F_IDLE;
        end
        default: st_q <= F_IDLE;
      endcase
      if (ack_in) ack_cnt <= ack_cnt - CW'(1);
    end
  end

  assign cpl_valid = cpl_q;
  assign cpl_rdata = cpl_data_q;
endmodule

// File: rtl/coh_svc_engine.sv
module coh_svc_engine
  import coh_pkg::*;
#(
  parameter int NODES = 4,
  parameter int LINES = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [3:0]               in_type,
  input  logic [$clog2(NODES)-1:0] in_src,
  input  logic [$clog2(LINES)-1:0] in_line,
  input  logic [1:0]               ln_state,
  input  logic [DW-1:0]            ln_data,
  output logic                     sv_we,
  output logic [$clog2(LINES)-1:0] sv_line,
  output logic [1:0]               sv_state,
  output logic                     s_valid,
  input  logic                     s_ready,
  output logic [3:0]               s_type,
  output logic [$clog2(NODES)-1:0] s_dst,
  output logic [$clog2(LINES)-1:0] s_line,
  output logic [DW-1:0]            s_data
);
  localparam int NW = $clog2(NODES);
  localparam int LW = $clog2(LINES);

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_DATA, S_REV} sst_e;

  sst_e          st_q;
  logic [NW-1:0] src_q;
  logic [LW-1:0] line_q;
  logic [DW-1:0] data_q;
  logic          take, is_inv;

  assign in_ready = (st_q == S_IDLE);
  assign take     = in_valid && in_ready;
  assign is_inv   = (in_type == MSG_INV);

  assign sv_we    = take && (is_inv || ln_state == LN_M);
  assign sv_line  = in_line;
  assign sv_state = is_inv ? LN_I : LN_S;

  always_comb begin
    s_valid = (st_q != S_IDLE);
    s_line  = line_q;
    s_data  = data_q;
    s_dst   = src_q;
    s_type  = MSG_DATA;
    case (st_q)
      S_ACK: s_type = MSG_INV_ACK;
      S_REV: begin
        s_type = MSG_REVISION;
        s_dst  = line_q[NW-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      src_q  <= '0;
      line_q <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (take) begin
          src_q  <= in_src;
          line_q <= in_line;
          data_q <= ln_data;
          st_q   <= is_inv ? S_ACK : S_DATA;
        end
        S_ACK:  if (s_ready) st_q <= S_IDLE;
        S_DATA: if (s_ready) st_q <= S_REV;
        S_REV:  if (s_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_req_agent.sv
module coh_req_agent
  import coh_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int LINES   = 16,
  parameter int DW      = 32,
  parameter int NODE_ID = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [$clog2(LINES)-1:0] req_line,
  input  logic [DW-1:0]            req_wdata,
  output logic                     cpl_valid,
  output logic [DW-1:0]            cpl_rdata,
  input  logic                     rx_valid,
  output logic                     rx_ready,
  input  logic [3:0]               rx_type,
  input  logic [$clog2(NODES)-1:0] rx_src,
  input  logic [$clog2(LINES)-1:0] rx_line,
  input  logic [DW-1:0]            rx_data,
  input  logic [NODES-1:0]         rx_sharers,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [3:0]               tx_type,
  output logic [$clog2(NODES)-1:0] tx_dst,
  output logic [$clog2(LINES)-1:0] tx_line,
  output logic [DW-1:0]            tx_data,
  input  logic [$clog2(LINES)-1:0] probe_line,
  output logic [1:0]               probe_state,
  output logic [DW-1:0]            probe_data
);
  localparam int NW = $clog2(NODES);
  localparam int LW = $clog2(LINES);

  logic          rx_is_svc, svc_in_valid, svc_in_ready, fsm_rx_valid;
  logic [1:0]    lk_state, sv_ln_state;
  logic [DW-1:0] lk_data, sv_ln_data;
  logic          st_we, sv_we;
  logic [LW-1:0] st_line, sv_line;
  logic [1:0]    st_state, sv_state;
  logic [DW-1:0] st_data;

  logic          m_valid, m_ready, s_valid, s_ready;
  logic [3:0]    m_type, s_type;
  logic [NW-1:0] m_dst, s_dst;
  logic [LW-1:0] m_line, s_line;
  logic [DW-1:0] m_data, s_data;

  // requests from other nodes go to the service engine; replies to this
  // node's own miss are always taken by the miss engine
  assign rx_is_svc    = (rx_type == MSG_DATA_REQ) || (rx_type == MSG_INV);
  assign svc_in_valid = rx_valid && rx_is_svc;
  assign fsm_rx_valid = rx_valid && !rx_is_svc;
  assign rx_ready     = rx_is_svc ? svc_in_ready : 1'b1;

  coh_line_store #(.LINES(LINES), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_we(st_we), .a_line(st_line), .a_state(st_state), .a_data(st_data),
    .b_we(sv_we), .b_line(sv_line), .b_state(sv_state),
    .ra_line(req_line), .ra_state(lk_state), .ra_data(lk_data),
    .rb_line(rx_line), .rb_state(sv_ln_state), .rb_data(sv_ln_data),
    .rc_line(probe_line), .rc_state(probe_state), .rc_data(probe_data)
  );

  coh_miss_fsm #(.NODES(NODES), .LINES(LINES), .DW(DW), .NODE_ID(NODE_ID)) u_miss (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_wdata(req_wdata),
    .lk_state(lk_state), .lk_data(lk_data),
    .cpl_valid(cpl_valid), .cpl_rdata(cpl_rdata),
    .rx_valid(fsm_rx_valid), .rx_type(rx_type), .rx_line(rx_line),
    .rx_data(rx_data), .rx_sharers(rx_sharers),
    .m_valid(m_valid), .m_ready(m_ready), .m_type(m_type), .m_dst(m_dst),
    .m_line(m_line), .m_data(m_data),
    .st_we(st_we), .st_line(st_line), .st_state(st_state), .st_data(st_data)
  );

  coh_svc_engine #(.NODES(NODES), .LINES(LINES), .DW(DW)) u_svc (
    .clk(clk), .rst_n(rst_n),
    .in_valid(svc_in_valid), .in_ready(svc_in_ready), .in_type(rx_type),
    .in_src(rx_src), .in_line(rx_line),
    .ln_state(sv_ln_state), .ln_data(sv_ln_data),
    .sv_we(sv_we), .sv_line(sv_line), .sv_state(sv_state),
    .s_valid(s_valid), .s_ready(s_ready), .s_type(s_type), .s_dst(s_dst),
    .s_line(s_line), .s_data(s_data)
  );

  // transmit arbiter: service replies first, but an offer that has been
  // stalled keeps the port until it is taken
  logic lock_q, lock_svc_q, sel_svc;

  assign sel_svc  = lock_q ? lock_svc_q : s_valid;
  assign tx_valid = sel_svc ? s_valid : m_valid;
  assign tx_type  = sel_svc ? s_type  : m_type;
  assign tx_dst   = sel_svc ? s_dst   : m_dst;
  assign tx_line  = sel_svc ? s_line  : m_line;
  assign tx_data  = sel_svc ? s_data  : m_data;
  assign s_ready  = sel_svc && tx_ready;
  assign m_ready  = !sel_svc && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_svc_q <= 1'b0;
    end else begin
      lock_q     <= tx_valid && !tx_ready;
      lock_svc_q <= sel_svc;
    end
  end
endmodule

// File: rtl/coh_req_agent_chk.sv
module coh_req_agent_chk #(
  parameter int NODES = 4,
  parameter int LINES = 16,
  parameter int DW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     cpl_valid,
  input logic                     rx_valid,
  input logic                     rx_ready,
  input logic [3:0]               rx_type,
  input logic [$clog2(NODES)-1:0] rx_src,
  input logic                     tx_valid,
  input logic                     tx_ready,
  input logic [3:0]               tx_type,
  input logic [$clog2(NODES)-1:0] tx_dst,
  input logic [$clog2(LINES)-1:0] tx_line,
  input logic [DW-1:0]            tx_data
);
  localparam int NW = $clog2(NODES);

  logic          pend_q;
  logic [7:0]    inv_out_q;
  logic [NW-1:0] inv_src_q;
  logic          tx_hs, rx_hs;

  assign tx_hs = tx_valid && tx_ready;
  assign rx_hs = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      inv_out_q <= '0;
      inv_src_q <= '0;
    end else begin
      if (tx_hs && (tx_type == 4'd0 || tx_type == 4'd1)) pend_q <= 1'b1;
      else if (cpl_valid) pend_q <= 1'b0;
      if (tx_hs && tx_type == 4'd3) inv_out_q <= inv_out_q + 8'd1;
      else if (rx_hs && rx_type == 4'd4 && inv_out_q != '0) inv_out_q <= inv_out_q - 8'd1;
      if (rx_hs && rx_type == 4'd3) inv_src_q <= rx_src;
    end
  end

  // R1
  miss_to_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && (tx_type == 4'd0 || tx_type == 4'd1)) |-> tx_dst == tx_line[NW-1:0]);

  // R12
  one_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cpl_valid) |-> !(req_valid && req_ready));

  // R8
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> inv_out_q == '0);

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_type) && $stable(tx_dst) &&
                                $stable(tx_line) && $stable(tx_data));

  // R10
  rev_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_type == 4'd6) |-> tx_dst == tx_line[NW-1:0]);

  // R11
  ack_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_type == 4'd4) |-> tx_dst == inv_src_q);
endmodule

bind coh_req_agent coh_req_agent_chk #(.NODES(NODES), .LINES(LINES), .DW(DW)) u_chk (.*);

// File: tb/coh_req_agent_tb.sv
module coh_req_agent_tb;
  localparam int NODES = 4, LINES = 16, DW = 32, SELF = 1;
  localparam int NW = 2, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [LW-1:0] req_line = '0;
  logic [DW-1:0] req_wdata = '0;
  logic cpl_valid;
  logic [DW-1:0] cpl_rdata;
  logic rx_valid = 0, rx_ready;
  logic [3:0] rx_type = '0;
  logic [NW-1:0] rx_src = '0;
  logic [LW-1:0] rx_line = '0;
  logic [DW-1:0] rx_data = '0;
  logic [NODES-1:0] rx_sharers = '0;
  logic tx_valid, tx_ready = 0;
  logic [3:0] tx_type;
  logic [NW-1:0] tx_dst;
  logic [LW-1:0] tx_line;
  logic [DW-1:0] tx_data;
  logic [LW-1:0] probe_line = '0;
  logic [1:0] probe_state;
  logic [DW-1:0] probe_data;

  coh_req_agent #(.NODES(NODES), .LINES(LINES), .DW(DW), .NODE_ID(SELF)) u_dut (.*);

  always #5 clk = ~clk;

  int errs = 0, checks = 0, cpl_cnt = 0, tx_seen = 0;
  logic [DW-1:0] cpl_last;
  bit done = 0;
  logic [1:0] m_st [LINES];
  logic [DW-1:0] m_dt [LINES];
  logic [3:0] g_type;
  logic [NW-1:0] g_dst;
  logic [LW-1:0] g_line;
  logic [DW-1:0] g_data;

  always @(negedge clk) begin
    if (cpl_valid) begin cpl_cnt++; cpl_last = cpl_rdata; end
    if (tx_valid) tx_seen++;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] home_of(input logic [LW-1:0] l);
    return l[NW-1:0];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic issue(input bit wr, input logic [LW-1:0] l, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_line = l; req_wdata = d;
    forever begin
      if (req_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  task automatic get_tx(input int stall);
    while (!tx_valid) @(negedge clk);
    g_type = tx_type; g_dst = tx_dst; g_line = tx_line; g_data = tx_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_type == g_type && tx_dst == g_dst && tx_line == g_line &&
          tx_data == g_data, "R13", "held message", {tx_type, tx_dst}, {g_type, g_dst});
    end
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic put_rx(input logic [3:0] t, input logic [NW-1:0] s, input logic [LW-1:0] l,
                        input logic [DW-1:0] d, input logic [NODES-1:0] sh);
    rx_valid = 1; rx_type = t; rx_src = s; rx_line = l; rx_data = d; rx_sharers = sh;
    forever begin
      if (rx_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    rx_valid = 0;
  endtask

  task automatic probe_chk(input logic [LW-1:0] l, input string rq);
    probe_line = l;
    #1;
    chk(probe_state == m_st[l] && probe_data == m_dt[l], rq, "line state/data",
        {probe_state, probe_data}, {m_st[l], m_dt[l]});
  endtask

  // mode for reads: 0 = clean home data, 1 = owner named by home
  task automatic do_op(input bit wr, input logic [LW-1:0] l, input logic [DW-1:0] wd,
                       input bit mode, input logic [NW-1:0] owner,
                       input logic [NODES-1:0] sh, input int stall);
    int c0, t0, n;
    bit hit;
    logic [DW-1:0] exp, hd;
    logic [NODES-1:0] want, got;
    logic [NW-1:0] q [NODES];
    c0 = cpl_cnt;
    hit = (m_st[l] == 2'd2) || (m_st[l] == 2'd1 && !wr);
    issue(wr, l, wd);
    t0 = tx_seen;
    if (hit) begin
      exp = wr ? wd : m_dt[l];
      repeat (3) @(negedge clk);
      #1;
      chk(tx_seen == t0, wr ? "R5" : "R2", "no message on hit", tx_seen - t0, 0);
      chk(cpl_cnt == c0 + 1 && cpl_last == exp, wr ? "R5" : "R2", "hit completion",
          cpl_last, exp);
      if (wr) begin m_st[l] = 2'd2; m_dt[l] = wd; end
      probe_chk(l, wr ? "R5" : "R2");
      return;
    end
    #1;
    chk(req_ready == 1'b0, "R12", "stall while miss", req_ready, 0);
    get_tx(stall);
    chk(g_type == (wr ? 4'd1 : 4'd0) && g_dst == home_of(l) && g_line == l,
        wr ? "R6" : "R1", "miss request", {g_type, g_dst}, {wr ? 4'd1 : 4'd0, home_of(l)});
    @(negedge clk);
    hd = $urandom;
    if (!wr) begin
      if (mode) begin
        put_rx(4'd8, home_of(l), l, DW'(owner), '0);
        get_tx($urandom_range(0, 2));
        chk(g_type == 4'd2 && g_dst == owner && g_line == l, "R4", "owner fetch",
            {g_type, g_dst}, {4'd2, owner});
        put_rx(4'd5, owner, l, hd, '0);
      end else begin
        put_rx(4'd5, home_of(l), l, hd, '0);
      end
      exp = hd;
      m_st[l] = 2'd1; m_dt[l] = hd;
    end else begin
      put_rx(4'd7, home_of(l), l, hd, sh);
      want = sh & ~(NODES'(1) << SELF);
      got = '0;
      n = $countones(want);
      for (int i = 0; i < n; i++) begin
        get_tx($urandom_range(0, 2));
        chk(g_type == 4'd3 && want[g_dst] && !got[g_dst], "R7", "invalidate target",
            {g_type, g_dst}, want);
        got[g_dst] = 1'b1;
        q[i] = g_dst;
      end
      repeat (2) @(negedge clk);
      #1;
      chk(got == want && tx_valid == 1'b0, n == 0 ? "R9" : "R7", "invalidate set",
          got, want);
      for (int i = n - 1; i > 0; i--) begin
        int j;
        logic [NW-1:0] tmp;
        j = $urandom_range(0, i);
        tmp = q[i]; q[i] = q[j]; q[j] = tmp;
      end
      for (int i = 0; i < n; i++) begin
        if (i == n - 1) begin
          repeat (3) @(negedge clk);
          #1;
          chk(cpl_cnt == c0, "R8", "write held for last ack", cpl_cnt - c0, 0);
        end
        put_rx(4'd4, q[i], l, '0, '0);
      end
      exp = wd;
      m_st[l] = 2'd2; m_dt[l] = wd;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(cpl_cnt == c0 + 1 && cpl_last == exp,
        wr ? (n == 0 ? "R9" : "R8") : (mode ? "R4" : "R3"), "miss completion", cpl_last, exp);
    probe_chk(l, wr ? "R8" : "R3");
  endtask

  task automatic serve_dreq(input logic [LW-1:0] l, input logic [NW-1:0] s);
    @(negedge clk);
    put_rx(4'd2, s, l, '0, '0);
    get_tx($urandom_range(0, 2));
    chk(g_type == 4'd5 && g_dst == s && g_data == m_dt[l], "R10", "data to requester",
        {g_type, g_dst, g_data}, {4'd5, s, m_dt[l]});
    get_tx($urandom_range(0, 2));
    chk(g_type == 4'd6 && g_dst == home_of(l) && g_data == m_dt[l], "R10", "revision to home",
        {g_type, g_dst, g_data}, {4'd6, home_of(l), m_dt[l]});
    if (m_st[l] == 2'd2) m_st[l] = 2'd1;
    probe_chk(l, "R10");
  endtask

  task automatic serve_inv(input logic [LW-1:0] l, input logic [NW-1:0] s);
    @(negedge clk);
    put_rx(4'd3, s, l, '0, '0);
    get_tx($urandom_range(0, 2));
    chk(g_type == 4'd4 && g_dst == s, "R11", "ack to sender", {g_type, g_dst}, {4'd4, s});
    m_st[l] = 2'd0;
    probe_chk(l, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < LINES; i++) begin m_st[i] = 2'd0; m_dt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(req_ready && !tx_valid && !cpl_valid, "R12", "reset idle", {req_ready, tx_valid}, 2'b10);
    for (int i = 0; i < LINES; i++) probe_chk(LW'(i), "R3");

    do_op(0, 4'd5, '0, 0, '0, '0, 3);
    do_op(0, 4'd5, '0, 0, '0, '0, 0);
    do_op(1, 4'd5, 32'hA5A5_0001, 0, '0, 4'b1111, 2);
    do_op(1, 4'd5, 32'h1234_5678, 0, '0, '0, 0);
    do_op(0, 4'd6, '0, 1, 2'd3, '0, 1);
    do_op(1, 4'd7, 32'h0BAD_F00D, 0, '0, 4'b0000, 0);
    do_op(1, 4'd9, 32'h0000_0099, 0, '0, 4'b0010, 0);
    serve_dreq(4'd5, 2'd2);
    do_op(0, 4'd5, '0, 0, '0, '0, 0);
    serve_inv(4'd5, 2'd3);
    do_op(1, 4'd5, 32'h5555_AAAA, 0, '0, 4'b1101, 1);

    for (int it = 0; it < 60; it++) begin
      int k;
      logic [LW-1:0] l;
      logic [NW-1:0] own;
      k = $urandom_range(0, 5);
      l = LW'($urandom_range(0, LINES - 1));
      own = NW'($urandom_range(0, NODES - 1));
      if (own == NW'(SELF)) own = own + NW'(1);
      case (k)
        0, 1: do_op(0, l, '0, 1'($urandom_range(0, 1)), own, '0, $urandom_range(0, 3));
        2, 3: do_op(1, l, $urandom, 0, '0, NODES'($urandom), $urandom_range(0, 3));
        4: if (m_st[l] == 2'd2) serve_dreq(l, own); else serve_inv(l, own);
        default: serve_inv(l, own);
      endcase
    end
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule